// File: doc/BRIEF.md
# Self-Starting Maximal-Length Pseudo-Random Bit Generator

This block produces a pseudo-random bit stream from a ten-stage shift register whose first stage is fed by the exclusive-OR of stage 3 and stage 10. That tap pair yields the longest possible sequence, 1023 bits, before the pattern repeats. The register has no reset and no seed load. If it powers up holding all zeros, it would stay there forever. To prevent this, a second exclusive-OR gate sits after the feedback gate. Its other input is a start signal, so a short pulse on that signal pushes a one into the loop and the register leaves the all-zero state.

The start signal may arrive without any timing relation to the clock. It first passes through a parameterised synchroniser and is then used as a level. The register moves one step only on cycles where the clock enable is high. The last stage drives a true output, and its complement drives a second output. Stage count, tap position and synchroniser depth are parameters that are checked when the design is elaborated.

Top module: `prbs_selfstart`

## Requirements
- R1: When the register holds all zeros and start stays low, the true output stays 0 on every clock, with or without enable.
- R2: Suppose start is captured high at one rising edge, called edge 0, and enable is high from then on. The true output is 0 after edge 10 and 1 after edge 11. This is two synchroniser stages plus ten register stages.
- R3: While start is idle, each new output bit equals the bit 3 enabled steps earlier XOR the bit 10 enabled steps earlier. This is feedback from stages 3 and 10 into stage 1.
- R4: Once running, the true output repeats with a period of exactly 1023 enabled cycles. No shorter period of 341, 93 or 33 cycles occurs, and each period holds 512 ones.
- R5: Once running with start idle, the true output never shows more than 9 zeros in a row across enabled cycles, and a run of 9 zeros does occur.
- R6: On a cycle with enable low, the register keeps its value, so the outputs do not change at the next edge.
- R7: The inverted output always equals the complement of the true output.
- R8: While the synchronised start level is high on an enabled cycle, the bit entering stage 1 is the inverse of the plain feedback, including when the generator is already running.
- R9: A start pulse whose synchronised level is high only on cycles with enable low has no effect, and the register stays where it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| en_i | input | 1 | Clock enable; the register shifts only when high |
| start_i | input | 1 | Power-on start indication, asynchronous, at least one clock wide |
| seq_o | output | 1 | True pseudo-random sequence (last stage) |
| seq_n_o | output | 1 | Inverted pseudo-random sequence |

## Verification
The hardest condition to reach is the all-zero lock-up state, because no port can load the register. The stimulus therefore depends on the register's power-up contents of zero. It holds that state through a long stretch with start low, and then through a start pulse that falls entirely in a window where enable is low. After that, a single pulse is issued with enable high. The exact edge on which the first one appears is checked, and then two full periods are collected to measure the period, the ones count and the longest zero run. A second start pulse is issued while the generator is running to show the injected inversion.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
   // Default geometry of the generator.
   parameter int unsigned PRBS_STAGES_DEF = 10;
   parameter int unsigned PRBS_TAP_DEF    = 3;
   parameter int unsigned PRBS_SYNC_DEF   = 2;

   // Number of enabled steps after which the checker treats an injection as flushed.
   function automatic int unsigned prbs_settle(input int unsigned stages,
                                               input int unsigned sync_depth);
      return stages + sync_depth + 4;
   endfunction
endpackage

// File: rtl/prbs_start_sync.sv
module prbs_start_sync #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk_i,
   input  logic async_i,
   output logic level_o
);
   generate
      if (DEPTH == 0) begin : g_bypass
         assign level_o = async_i;
      end else begin : g_chain
         logic [DEPTH-1:0] pipe_q;
         always_ff @(posedge clk_i) begin
            pipe_q[0] <= async_i;
            for (int k = 1; k < int'(DEPTH); k++) begin
               pipe_q[k] <= pipe_q[k-1];
            end
         end
         assign level_o = pipe_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/prbs_loop_mix.sv
module prbs_loop_mix (
   input  logic tap_a_i,
   input  logic tap_b_i,
   input  logic kick_i,
   output logic head_o
);
   logic fb_plain;

   // First gate: modulo-2 feedback of the two taps.
   assign fb_plain = tap_a_i ^ tap_b_i;
   // Second gate: start level inverts the feedback while high.
   assign head_o   = fb_plain ^ kick_i;
endmodule

// File: rtl/prbs_shift_core.sv
module prbs_shift_core #(
   parameter int unsigned STAGES    = 10,
   parameter int unsigned TAP_STAGE = 3
) (
   input  logic clk_i,
   input  logic en_i,
   input  logic kick_i,
   output logic last_o
);
   localparam int unsigned TAP_IDX  = TAP_STAGE - 1;
   localparam int unsigned LAST_IDX = STAGES - 1;

   logic [STAGES-1:0] stage_q;
   logic              head_d;

   prbs_loop_mix u_mix (
      .tap_a_i (stage_q[TAP_IDX]),
      .tap_b_i (stage_q[LAST_IDX]),
      .kick_i  (kick_i),
      .head_o  (head_d)
   );

   // No reset: start-up comes only through the loop injection.
   always_ff @(posedge clk_i) begin
      if (en_i) begin
         stage_q <= {stage_q[STAGES-2:0], head_d};
      end
   end

   assign last_o = stage_q[LAST_IDX];
endmodule

// File: rtl/prbs_selfstart.sv
module prbs_selfstart #(
   parameter int unsigned STAGES      = prbs_pkg::PRBS_STAGES_DEF,
   parameter int unsigned TAP_STAGE   = prbs_pkg::PRBS_TAP_DEF,
   parameter int unsigned SYNC_STAGES = prbs_pkg::PRBS_SYNC_DEF
) (
   input  logic clk_i,
   input  logic en_i,
   input  logic start_i,
   output logic seq_o,
   output logic seq_n_o
);
   generate
      if (STAGES < 3) begin : g_bad_stages
         $error("prbs_selfstart: STAGES must be at least 3");
      end
      if (TAP_STAGE < 2 || TAP_STAGE >= STAGES) begin : g_bad_tap
         $error("prbs_selfstart: TAP_STAGE must lie strictly inside the register");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("prbs_selfstart: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic start_lvl;
   logic tail;

   prbs_start_sync #(.DEPTH(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .async_i (start_i),
      .level_o (start_lvl)
   );

   prbs_shift_core #(.STAGES(STAGES), .TAP_STAGE(TAP_STAGE)) u_core (
      .clk_i  (clk_i),
      .en_i   (en_i),
      .kick_i (start_lvl),
      .last_o (tail)
   );

   assign seq_o   = tail;
   assign seq_n_o = ~tail;
endmodule

// File: rtl/prbs_selfstart_chk.sv
module prbs_selfstart_chk #(
   parameter int unsigned STAGES      = 10,
   parameter int unsigned TAP_STAGE   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk_i,
   input logic en_i,
   input logic start_i,
   input logic seq_o,
   input logic seq_n_o
);
   localparam int unsigned SETTLE = prbs_pkg::prbs_settle(STAGES, SYNC_STAGES);
   localparam int unsigned CW     = $clog2(SETTLE + 1);
   localparam int unsigned RW     = $clog2(STAGES + 2);

   logic              armed_q;
   logic [CW-1:0]     since_q;
   logic [STAGES-1:0] hist_q;
   logic [RW-1:0]     run_q;
   logic              live_q;
   logic              settled;

   assign settled = (since_q == CW'(SETTLE));

   always_ff @(posedge clk_i) begin
      armed_q <= 1'b1;
      if (start_i) since_q <= '0;
      else if (en_i && !settled) since_q <= since_q + 1'b1;
      if (en_i) hist_q <= {hist_q[STAGES-2:0], seq_o};
      if (start_i) live_q <= 1'b0;
      else if (en_i && settled && seq_o) live_q <= 1'b1;
      if (start_i) run_q <= '0;
      else if (en_i) run_q <= seq_o ? '0 : ((run_q == RW'(STAGES)) ? run_q : run_q + 1'b1);
   end

   // R3
   recur_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      (en_i && settled) |=> (seq_o == ($past(hist_q[TAP_STAGE-2]) ^ $past(hist_q[STAGES-2]))));

   // R5
   zero_run_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      live_q |-> (run_q < RW'(STAGES)));

   // R6
   hold_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      !en_i |=> ($stable(seq_o) && $stable(seq_n_o)));

   // R7
   compl_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      seq_n_o == ~seq_o);
endmodule

bind prbs_selfstart prbs_selfstart_chk #(
   .STAGES(STAGES), .TAP_STAGE(TAP_STAGE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk_i(clk_i), .en_i(en_i), .start_i(start_i), .seq_o(seq_o), .seq_n_o(seq_n_o)
);

// File: tb/tb_prbs_selfstart.sv
module tb_prbs_selfstart;
   logic clk = 1'b0;
   logic en = 1'b0;
   logic start = 1'b0;
   logic seq, seq_n;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model of the requirements: 2 sync stages, taps 3 and 10.
   logic [9:0] msr = '0;
   logic ms1 = 1'b0, ms2 = 1'b0;

   always #5 clk = ~clk;

   prbs_selfstart dut (
      .clk_i(clk), .en_i(en), .start_i(start), .seq_o(seq), .seq_n_o(seq_n)
   );

   always @(posedge clk) begin
      ms1 <= start;
      ms2 <= ms1;
      if (en) msr <= {msr[8:0], msr[2] ^ msr[9] ^ ms2};
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // R1: lock-up with all-zero register and idle start
   task automatic t_lockup();
      int ones = 0;
      @(negedge clk);
      chk(seq == 1'b0, "R1 initial output", seq, 0);
      for (int i = 0; i < 40; i++) begin
         en = (i % 3) != 0;
         step();
         if (seq) ones++;
      end
      chk(ones == 0, "R1 ones seen while locked", ones, 0);
   endtask

   // R9: start pulse only during disabled cycles
   task automatic t_gated_start();
      int ones = 0;
      en = 1'b0;
      start = 1'b1;
      step();
      start = 1'b0;
      repeat (6) step();
      en = 1'b1;
      for (int i = 0; i < 30; i++) begin
         step();
         if (seq) ones++;
      end
      chk(ones == 0, "R9 pulse with enable low", ones, 0);
   endtask

   // R2: exact escape latency
   task automatic t_escape();
      en = 1'b1;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (9) @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(seq == 1'b0, "R2 output after edge 10", seq, 0);
      step();
      chk(seq == 1'b1, "R2 output after edge 11", seq, 1);
   endtask

   // R3, R4, R5, R7: two full periods against the model
   task automatic t_sequence();
      logic [2045:0] bits;
      int mism = 0, cmis = 0, ones = 0, run = 0, maxrun = 0, rep = 0;
      int sub341 = 0, sub93 = 0, sub33 = 0;
      en = 1'b1;
      repeat (30) step();
      for (int i = 0; i < 2046; i++) begin
         step();
         bits[i] = seq;
         if (seq !== msr[9]) mism++;
         if (seq_n !== ~seq) cmis++;
      end
      chk(mism == 0, "R3 sequence vs taps 3 and 10", mism, 0);
      chk(cmis == 0, "R7 inverted output", cmis, 0);
      for (int i = 0; i < 1023; i++) begin
         if (bits[i] != bits[i+1023]) rep++;
         if (bits[i] != bits[i+341]) sub341++;
         if (bits[i] != bits[i+93]) sub93++;
         if (bits[i] != bits[i+33]) sub33++;
         if (bits[i]) ones++;
      end
      chk(rep == 0, "R4 repeats after 1023", rep, 0);
      chk(sub341 != 0 && sub93 != 0 && sub33 != 0, "R4 no shorter period",
          (sub341 == 0) + (sub93 == 0) + (sub33 == 0), 0);
      chk(ones == 512, "R4 ones per period", ones, 512);
      for (int i = 0; i < 2046; i++) begin
         run = bits[i] ? 0 : run + 1;
         if (run > maxrun) maxrun = run;
      end
      chk(maxrun == 9, "R5 longest zero run", maxrun, 9);
   endtask

   // R6: hold while disabled
   task automatic t_hold();
      logic held;
      int moved = 0, mism = 0;
      en = 1'b0;
      held = seq;
      for (int i = 0; i < 15; i++) begin
         step();
         if (seq !== held || seq_n !== ~held) moved++;
      end
      chk(moved == 0, "R6 outputs stable with enable low", moved, 0);
      en = 1'b1;
      for (int i = 0; i < 40; i++) begin
         step();
         if (seq !== msr[9]) mism++;
      end
      chk(mism == 0, "R6 resumes in order", mism, 0);
   endtask

   // R8: injection while running
   task automatic t_restart();
      int mism = 0;
      int diff = 0;
      logic [9:0] plain;
      en = 1'b1;
      repeat (57) step();
      start = 1'b1;
      step();
      start = 1'b0;
      step();
      plain = msr;
      for (int i = 0; i < 80; i++) begin
         step();
         if (seq !== msr[9]) mism++;
         if (i < 70) begin
            plain = {plain[8:0], plain[2] ^ plain[9] ^ (i == 0)};
         end
      end
      chk(mism == 0, "R8 inverted feed while running", mism, 0);
      for (int i = 0; i < 30; i++) begin
         step();
         if (seq !== msr[9]) diff++;
      end
      chk(diff == 0, "R8 sequence continues after restart", diff, 0);
   endtask

   initial begin
      t_lockup();
      t_gated_start();
      t_escape();
      t_sequence();
      t_hold();
      t_restart();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule